// File: doc/BRIEF.md
# Vectored Interrupt Dispatch Unit

This block turns a set of numbered, level-sensitive interrupt lines into one vectored interrupt delivered to a processor. Each of the 64 vector lines is edge-detected. When a line rises while the unit is idle, the unit latches a three-word dispatch record, sets a busy flag, and raises a processor interrupt request that carries a fixed vectored trap type. It also emits a one-cycle wake pulse for a halted core.

A 16-line legacy peripheral interrupt bus is folded into the same vector space. Five of its lines are routed, each to a fixed vector number. The other legacy lines are dropped.

Delivery has a single slot. While busy is set, newly raised lines are ignored and the latched record stays unchanged. A falling edge on any line while busy clears busy and withdraws the request. A line that stays high does not trigger again after busy clears.

Top module: `vec_irq_dispatch`

## Requirements
- R1: After reset, busy, irq_req, irq_trap and wake are 0, and all three record words are 0.
- R2: A rising line while busy is 0 sets busy and irq_req one clock edge later. At that point irq_trap shows the trap code 0x60.
- R3: On a delivery, record word 0 becomes 0x7C0 OR the vector number (bits 10:6 hold 0x1F and bits 5:0 hold the vector). Words 1 and 2 read 0.
- R4: While busy is 1, a further rising line neither starts a delivery nor changes record word 0.
- R5: A falling edge on any line while busy is 1 clears busy and irq_req on the next edge. Record word 0 keeps its value.
- R6: Legacy lines are routed as follows: line 7 to vector 0x22, line 6 to 0x27, line 1 to 0x29, line 12 to 0x2A, and line 4 to 0x2B.
- R7: Every other legacy line has no effect. Busy stays 0 and record word 0 is unchanged.
- R8: When several lines rise in the same cycle, the lowest-numbered vector is delivered.
- R9: A line that stays high does not cause a second delivery after busy clears.
- R10: wake is high for exactly the one cycle in which busy first reads 1 for a delivery.
- R11: Every vector number from 0 to 63 can be delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vec_req | input | 64 | Level-sensitive vector request lines |
| legacy_irq | input | 16 | Legacy peripheral interrupt lines |
| busy | output | 1 | A delivery is pending |
| irq_req | output | 1 | Vectored interrupt request to the processor |
| irq_trap | output | 8 | Trap code, valid while irq_req is 1 |
| wake | output | 1 | One-cycle wake pulse for a halted processor |
| rec_w0 | output | 64 | Record word 0: fixed field and vector number |
| rec_w1 | output | 64 | Record word 1 (zero) |
| rec_w2 | output | 64 | Record word 2 (zero) |

## Verification
The assertions check several rules on every cycle: an idle unit becomes busy after a detected rise, record word 0 holds steady while busy, a fall clears busy, the fixed field is present, and wake coincides with busy rising. Which vector wins among simultaneous rises, the exact routing of the legacy lines, the silence of unmapped lines, and the absence of retriggering from a steady high line all depend on chosen stimulus. Those behaviours are covered only by the bench's sweeps over all 64 vectors and all 16 legacy lines.

// File: rtl/vec_irq_pkg.sv
// Package: shared constants and the legacy routing table for the dispatch unit.
// Assumes a 64-entry vector space so that the vector fits in bits 5:0 of word 0.
package vec_irq_pkg;
    localparam int unsigned NUM_VEC    = 64;
    localparam int unsigned NUM_LEGACY = 16;
    localparam int unsigned WORD_W     = 64;
    localparam int unsigned VEC_W      = $clog2(NUM_VEC);
    localparam int unsigned FIELD_SHIFT = 6;
    localparam logic [4:0]  FIXED_FIELD = 5'h1F;
    localparam logic [7:0]  TRAP_CODE   = 8'h60;

    // Returns the routed vector for a legacy line, or -1 when the line is dropped.
    function automatic int legacy_target(input int line);
        case (line)
            7:       return 'h22;
            6:       return 'h27;
            1:       return 'h29;
            12:      return 'h2A;
            4:       return 'h2B;
            default: return -1;
        endcase
    endfunction
endpackage

// File: rtl/vec_legacy_router.sv
// Legacy router: folds routed legacy lines onto their fixed vector positions.
// Assumes every routed target is below N_VEC. Unrouted lines drive nothing.
module vec_legacy_router
    import vec_irq_pkg::*;
#(
    parameter int unsigned N_VEC = NUM_VEC,
    parameter int unsigned N_LEG = NUM_LEGACY
) (
    input  logic [N_LEG-1:0] legacy_in,
    output logic [N_VEC-1:0] legacy_vec
);
    logic [N_VEC-1:0] contrib [N_LEG];

    for (genvar g = 0; g < N_LEG; g++) begin : g_line
        localparam int TGT = legacy_target(g);
        if (TGT >= 0 && TGT < int'(N_VEC)) begin : g_routed
            assign contrib[g] = {{(N_VEC-1){1'b0}}, legacy_in[g]} << TGT;
        end else begin : g_dropped
            assign contrib[g] = '0;
        end
    end

    // Purpose: OR every line's contribution into one vector-wide bus.
    always_comb begin
        legacy_vec = '0;
        for (int i = 0; i < int'(N_LEG); i++) legacy_vec = legacy_vec | contrib[i];
    end
endmodule

// File: rtl/vec_edge_detect.sv
// Edge detector: compares each line with its value from the previous cycle.
// Assumes the inputs are synchronous to clk. The history clears to 0 on reset.
module vec_edge_detect #(
    parameter int unsigned W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lines,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev_q;

    // Purpose: keep the sampled history of every line.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lines;
    end

    assign rise = lines & ~prev_q;
    assign fall = ~lines & prev_q;
endmodule

// File: rtl/vec_lowest_pick.sv
// Priority picker: returns the lowest set index of a request vector.
// Assumes W is a power of two no larger than 2**IW.
module vec_lowest_pick #(
    parameter int unsigned W  = 64,
    parameter int unsigned IW = $clog2(W)
) (
    input  logic [W-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Purpose: scan from the top down so that the lowest set bit is kept.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = int'(W) - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/vec_irq_dispatch.sv
// Top: single-slot vectored interrupt dispatch.
// Assumes level-sensitive synchronous request lines. Any falling line acknowledges.
module vec_irq_dispatch
    import vec_irq_pkg::*;
#(
    parameter int unsigned N_VEC  = NUM_VEC,
    parameter int unsigned N_LEG  = NUM_LEGACY,
    parameter int unsigned W_WORD = WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_VEC-1:0]  vec_req,
    input  logic [N_LEG-1:0]  legacy_irq,
    output logic              busy,
    output logic              irq_req,
    output logic [7:0]        irq_trap,
    output logic              wake,
    output logic [W_WORD-1:0] rec_w0,
    output logic [W_WORD-1:0] rec_w1,
    output logic [W_WORD-1:0] rec_w2
);
    localparam int unsigned IW = $clog2(N_VEC);
    localparam int unsigned PAD_W = W_WORD - FIELD_SHIFT - 5;

    logic [N_VEC-1:0] legacy_vec, lines, rise, fall;
    logic             pick_found;
    logic [IW-1:0]    pick_idx;
    logic             busy_q, wake_q;
    logic [W_WORD-1:0] w0_q;

    vec_legacy_router #(.N_VEC(N_VEC), .N_LEG(N_LEG)) u_router (
        .legacy_in (legacy_irq),
        .legacy_vec(legacy_vec)
    );

    assign lines = vec_req | legacy_vec;

    vec_edge_detect #(.W(N_VEC)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lines(lines),
        .rise (rise),
        .fall (fall)
    );

    vec_lowest_pick #(.W(N_VEC), .IW(IW)) u_pick (
        .req  (rise),
        .found(pick_found),
        .idx  (pick_idx)
    );

    // Purpose: accept a delivery when idle and release it on any falling line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            wake_q <= 1'b0;
            w0_q   <= '0;
        end else begin
            wake_q <= 1'b0;
            if (busy_q) begin
                if (|fall) busy_q <= 1'b0;
            end else if (pick_found) begin
                busy_q <= 1'b1;
                wake_q <= 1'b1;
                w0_q   <= {{PAD_W{1'b0}}, FIXED_FIELD,
                           {(FIELD_SHIFT-IW){1'b0}}, pick_idx};
            end
        end
    end

    assign busy     = busy_q;
    assign irq_req  = busy_q;
    assign irq_trap = busy_q ? TRAP_CODE : 8'h00;
    assign wake     = wake_q;
    assign rec_w0   = w0_q;
    assign rec_w1   = '0;
    assign rec_w2   = '0;
endmodule

// File: rtl/vec_irq_dispatch_chk.sv
// Checker: cycle rules of the dispatch unit, attached to the top through bind.
module vec_irq_dispatch_chk #(
    parameter int unsigned N_VEC  = 64,
    parameter int unsigned W_WORD = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_VEC-1:0]  rise,
    input logic [N_VEC-1:0]  fall,
    input logic              busy,
    input logic              wake,
    input logic [W_WORD-1:0] rec_w0
);
    AST_SET_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (|rise)) |=> busy); // R2
    AST_RECORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(|fall)) |=> (busy && $stable(rec_w0))); // R4
    AST_CLEAR_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (|fall)) |=> (!busy && $stable(rec_w0))); // R5
    AST_FIXED_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rec_w0[10:6] == 5'h1F)); // R3
    AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> $rose(busy)); // R10
endmodule

bind vec_irq_dispatch vec_irq_dispatch_chk #(.N_VEC(N_VEC), .W_WORD(W_WORD)) u_chk (
    .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
    .busy(busy), .wake(wake), .rec_w0(rec_w0)
);

// File: tb/vec_irq_dispatch_tb.sv
module vec_irq_dispatch_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] vec_req = '0;
    logic [15:0] legacy_irq = '0;
    logic        busy, irq_req, wake;
    logic [7:0]  irq_trap;
    logic [63:0] rec_w0, rec_w1, rec_w2;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    vec_irq_dispatch u_dut (
        .clk(clk), .rst_n(rst_n), .vec_req(vec_req), .legacy_irq(legacy_irq),
        .busy(busy), .irq_req(irq_req), .irq_trap(irq_trap), .wake(wake),
        .rec_w0(rec_w0), .rec_w1(rec_w1), .rec_w2(rec_w2)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int leg_map(input int l);
        case (l)
            1: return 'h29; 4: return 'h2B; 6: return 'h27;
            7: return 'h22; 12: return 'h2A; default: return -1;
        endcase
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin
        #1_600_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [63:0] last_w0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 busy", {63'd0, busy}, 64'd0);
        chk("R1 irq", {63'd0, irq_req}, 64'd0);
        chk("R1 trap", {56'd0, irq_trap}, 64'd0);
        chk("R1 wake", {63'd0, wake}, 64'd0);
        chk("R1 w0", rec_w0, 64'd0);

        // R11 sweep of every vector, with R2, R3, R5 and R10 on each
        for (int v = 0; v < 64; v++) begin
            vec_req[v] = 1'b1;
            tick();
            chk("R2 busy", {63'd0, busy}, 64'd1);
            chk("R2 trap", {56'd0, irq_trap}, 64'h60);
            chk("R11 R3 w0", rec_w0, 64'h7C0 | 64'(v));
            chk("R3 w1w2", rec_w1 | rec_w2, 64'd0);
            chk("R10 wake on", {63'd0, wake}, 64'd1);
            tick();
            chk("R10 wake off", {63'd0, wake}, 64'd0);
            vec_req[v] = 1'b0;
            tick();
            chk("R5 busy clear", {63'd0, busy, irq_req}, 64'd0);
            chk("R5 w0 kept", rec_w0, 64'h7C0 | 64'(v));
        end

        // R6 and R7: sweep of every legacy line
        for (int l = 0; l < 16; l++) begin
            last_w0 = rec_w0;
            legacy_irq[l] = 1'b1;
            tick();
            if (leg_map(l) >= 0) begin
                chk("R6 busy", {63'd0, busy}, 64'd1);
                chk("R6 vector", rec_w0, 64'h7C0 | 64'(leg_map(l)));
            end else begin
                chk("R7 busy", {63'd0, busy}, 64'd0);
                chk("R7 w0", rec_w0, last_w0);
            end
            legacy_irq[l] = 1'b0;
            tick();
            chk("R5 legacy clear", {63'd0, busy}, 64'd0);
        end

        // R4: ignored while busy
        vec_req[5] = 1'b1;
        tick();
        vec_req[9] = 1'b1;
        tick();
        chk("R4 busy kept", {63'd0, busy}, 64'd1);
        chk("R4 w0 kept", rec_w0, 64'h7C5);
        tick();
        chk("R4 still", rec_w0, 64'h7C5);
        vec_req[9] = 1'b0;
        tick();
        chk("R5 clear by other line", {63'd0, busy}, 64'd0);
        // R9: line 5 still high, no retrigger
        tick();
        tick();
        chk("R9 no retrigger", {63'd0, busy}, 64'd0);
        vec_req[5] = 1'b0;
        tick();

        // R8: simultaneous rises
        vec_req[40] = 1'b1; vec_req[20] = 1'b1; vec_req[7] = 1'b1;
        tick();
        chk("R8 lowest", rec_w0, 64'h7C7);
        vec_req = '0;
        tick();
        // R8 with legacy line 7 (vector 0x22) against vector 0x30
        vec_req[48] = 1'b1; legacy_irq[7] = 1'b1;
        tick();
        chk("R8 legacy mix", rec_w0, 64'h7E2);
        vec_req = '0; legacy_irq = '0;
        tick();
        chk("R5 final", {63'd0, busy}, 64'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule